// File: doc/BRIEF.md
# Push-Button Sine Tone Generator

This block plays a sine tone on a 4-bit binary-weighted resistor DAC. Three push-button lines choose the note. Each note has its own sample period, counted by a down-counter. Whenever the counter expires, the block puts the next code from a fixed 32-step sine table on the DAC pins and pulses a one-cycle sample strobe. The tone's frequency is therefore the clock rate divided by the sample period and by 32.

When no button is held, the block is silent. The DAC rests at mid-scale and the table position returns to its start, so the next note always begins at the first table step. When the player moves from one note to another, the new sample period takes effect at once and the waveform continues from its current table position.

Top module: `tone_wavetable_gen`

## Requirements
- R1: The sine table holds 32 codes, stepped through in this order: 8,9,11,12,13,14,14,15,15,15,14,14,13,12,11,9,8,7,5,4,3,2,2,1,1,1,2,2,3,4,5,7. On every sample strobe the DAC pins carry the code at the current table position. Between strobes the DAC code does not change.
- R2: Each strobe moves the table position forward by exactly one step. After position 31 the next position is 0.
- R3: The sample period of a note is round(CLK_HZ × 1000 / (note_mHz × 32)) clocks. While the selected note is unchanged, consecutive strobes are exactly that many clocks apart. The counter runs from period−1 down to 0. With the default values (50 MHz clock; notes of 440, 523.3 and 659.3 Hz) the periods are 3551, 2986 and 2370 clocks.
- R4: The buttons map to notes as follows: `btn_i[0]` selects note 1 (440 Hz), `btn_i[1]` selects note 2 (523.3 Hz) and `btn_i[2]` selects note 3 (659.3 Hz). When several buttons are held, the lowest-numbered one wins.
- R5: With no button held, the block is stopped. The counter is halted, no strobe occurs, the DAC holds mid-scale code 8 and the table position returns to 0, so the first strobe of the next note outputs code 8 (step 0).
- R6: When the selection changes from one note to a different note, the counter reloads with the new period at once. The table position carries on without being reset.
- R7: The buttons pass through a two-flop synchronizer and a registered selector. Count rising clock edges from the first edge after a change in the button inputs. When that change starts a note, or switches to a different note, the first strobe of the new note appears on edge P+4, where P is the new note's period.
- R8: While reset is held and right after it is released, the DAC outputs code 8 and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_i | input | 3 | Asynchronous push-button lines, bit n selects note n+1 |
| dac_o | output | 4 | Code for the binary-weighted resistor DAC (weights 1, 2, 4, 8) |
| strobe_o | output | 1 | One-cycle pulse in the cycle a new sample appears on `dac_o` |

## Verification
The main function is tried under several kinds of input.

- **Single held buttons** measure the exact strobe spacing of each note.
- **Several buttons held at once** separate a correct lowest-wins priority from a wrong one, because each note has a different period.
- **Presses that keep the same winning note** must not disturb the counter.
- **Switches straight from one note to another** show whether the reload happens at once (through first-strobe latency) and whether the table position is kept (through the sequence of codes).
- **Returns to silence** check the mid-scale rest and the restart from step 0.

Long holds carry the position past step 31, so the wrap is checked too. Random button patterns then mix all of these.

// File: rtl/tone_pkg.sv
// Package: shared types and constant functions for the wavetable tone generator.
// Assumes a fixed 32-step, 4-bit sine table; everything else is parameterised.
package tone_pkg;

    localparam int WAVE_LEN = 32;
    localparam int IDX_W    = $clog2(WAVE_LEN);
    localparam int DAC_W    = 4;
    localparam logic [DAC_W-1:0] MIDSCALE = 4'd8;

    typedef enum logic [1:0] {
        SEL_STOP = 2'd0,
        SEL_N1   = 2'd1,
        SEL_N2   = 2'd2,
        SEL_N3   = 2'd3
    } tone_sel_e;

    // Sine table lookup, one full period over 32 steps.
    function automatic logic [DAC_W-1:0] sine_code(input logic [IDX_W-1:0] pos);
        case (pos)
            5'd0:  sine_code = 4'd8;
            5'd1:  sine_code = 4'd9;
            5'd2:  sine_code = 4'd11;
            5'd3:  sine_code = 4'd12;
            5'd4:  sine_code = 4'd13;
            5'd5:  sine_code = 4'd14;
            5'd6:  sine_code = 4'd14;
            5'd7:  sine_code = 4'd15;
            5'd8:  sine_code = 4'd15;
            5'd9:  sine_code = 4'd15;
            5'd10: sine_code = 4'd14;
            5'd11: sine_code = 4'd14;
            5'd12: sine_code = 4'd13;
            5'd13: sine_code = 4'd12;
            5'd14: sine_code = 4'd11;
            5'd15: sine_code = 4'd9;
            5'd16: sine_code = 4'd8;
            5'd17: sine_code = 4'd7;
            5'd18: sine_code = 4'd5;
            5'd19: sine_code = 4'd4;
            5'd20: sine_code = 4'd3;
            5'd21: sine_code = 4'd2;
            5'd22: sine_code = 4'd2;
            5'd23: sine_code = 4'd1;
            5'd24: sine_code = 4'd1;
            5'd25: sine_code = 4'd1;
            5'd26: sine_code = 4'd2;
            5'd27: sine_code = 4'd2;
            5'd28: sine_code = 4'd3;
            5'd29: sine_code = 4'd4;
            5'd30: sine_code = 4'd5;
            default: sine_code = 4'd7;
        endcase
    endfunction

    // Clocks per sample, rounded to nearest: clk / (note * table length).
    function automatic int unsigned sample_period(input longint unsigned clk_hz,
                                                  input longint unsigned note_mhz);
        longint unsigned den;
        den = note_mhz * longint'(WAVE_LEN);
        sample_period = int'((clk_hz * 64'd1000 + den / 2) / den);
    endfunction

    // Largest of three values, used to size the counter.
    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        max3 = (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tone_key_select.sv
// Module: tone_key_select
// Brings the three asynchronous button lines into the clock domain through
// two flops, then resolves them to one note with lowest-bit priority.
// The resolved selection is registered, giving three cycles of input latency.
// Assumes buttons are already debounced externally.
module tone_key_select
    import tone_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] btn_i,
    output tone_sel_e  sel_o
);

    logic [2:0] meta_q;
    logic [2:0] sync_q;
    tone_sel_e  sel_d;
    tone_sel_e  sel_q;

    // Two-flop synchronizer for the button lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= btn_i;
            sync_q <= meta_q;
        end
    end

    // Lowest-numbered held button wins; none held means stop.
    always_comb begin
        if (sync_q[0])      sel_d = SEL_N1;
        else if (sync_q[1]) sel_d = SEL_N2;
        else if (sync_q[2]) sel_d = SEL_N3;
        else                sel_d = SEL_STOP;
    end

    // Register the resolved selection.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= SEL_STOP;
        else        sel_q <= sel_d;
    end

    assign sel_o = sel_q;

    assert_low_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q[0] |=> sel_o == SEL_N1);

    assert_idle_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q == 3'b000 |=> sel_o == SEL_STOP);

endmodule

// File: rtl/tone_sample_timer.sv
// Module: tone_sample_timer
// Down-counter that sets the sample rate. It counts from period-1 to 0 and
// raises tick_o for one cycle at 0. It reloads at once when the note changes
// and is halted at 0 while stopped.
// Assumes every period is at least 1.
module tone_sample_timer
    import tone_pkg::*;
#(
    parameter int unsigned PERIOD_N1 = 3551,
    parameter int unsigned PERIOD_N2 = 2986,
    parameter int unsigned PERIOD_N3 = 2370,
    parameter int unsigned CNT_W     = 12
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tone_sel_e sel_i,
    output logic      tick_o
);

    localparam logic [CNT_W-1:0] P1 = CNT_W'(PERIOD_N1);
    localparam logic [CNT_W-1:0] P2 = CNT_W'(PERIOD_N2);
    localparam logic [CNT_W-1:0] P3 = CNT_W'(PERIOD_N3);

    logic [CNT_W-1:0] cur_period;
    logic [CNT_W-1:0] cnt_q;
    tone_sel_e        prev_q;
    logic             running;
    logic             changed;

    // Period for the currently selected note.
    always_comb begin
        case (sel_i)
            SEL_N1:  cur_period = P1;
            SEL_N2:  cur_period = P2;
            SEL_N3:  cur_period = P3;
            default: cur_period = '0;
        endcase
    end

    assign running = (sel_i != SEL_STOP);
    assign changed = (sel_i != prev_q);
    assign tick_o  = running && !changed && (cnt_q == '0);

    // Remember last cycle's selection to spot note changes.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= SEL_STOP;
        else        prev_q <= sel_i;
    end

    // Count down, reload on expiry or note change, halt while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) cnt_q <= '0;
        else if (changed || cnt_q == '0) cnt_q <= cur_period - 1'b1;
        else cnt_q <= cnt_q - 1'b1;
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !changed) |-> cnt_q <= cur_period - 1'b1);

    assert_tick_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> cnt_q == $past(cur_period) - 1'b1);

    assert_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (cnt_q == '0 && !tick_o));

    assert_change_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && changed) |=> cnt_q == $past(cur_period) - 1'b1);

endmodule

// File: rtl/tone_wave_stepper.sv
// Module: tone_wave_stepper
// Holds the table position and drives the DAC code. Each tick registers the
// code at the current position, advances the position with wrap, and
// registers a strobe aligned with the new code. While stopped it rests at
// mid-scale and rewinds to position 0.
module tone_wave_stepper
    import tone_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tone_sel_e        sel_i,
    input  logic             tick_i,
    output logic [DAC_W-1:0] dac_o,
    output logic             strobe_o
);

    logic [IDX_W-1:0] idx_q;
    logic [DAC_W-1:0] dac_q;
    logic             strobe_q;
    logic             stopped;

    assign stopped = (sel_i == SEL_STOP);

    // Step the table on each tick; rest at mid-scale while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || stopped) begin
            idx_q    <= '0;
            dac_q    <= MIDSCALE;
            strobe_q <= 1'b0;
        end else if (tick_i) begin
            idx_q    <= idx_q + 1'b1;
            dac_q    <= sine_code(idx_q);
            strobe_q <= 1'b1;
        end else begin
            strobe_q <= 1'b0;
        end
    end

    assign dac_o    = dac_q;
    assign strobe_o = strobe_q;

    assert_idx_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> idx_q == IDX_W'($past(idx_q) + 1'b1));

    assert_hold_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_o && $past(sel_i) != SEL_STOP) |-> $stable(dac_o));

    assert_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> (dac_o == MIDSCALE && idx_q == '0 && !strobe_o));

endmodule

// File: rtl/tone_wavetable_gen.sv
// Module: tone_wavetable_gen (top)
// Button-selected sine tone generator for a 4-bit binary-weighted DAC.
// Note frequencies are given in millihertz and turned into sample periods
// at elaboration time from CLK_HZ and the 32-step table length.
module tone_wavetable_gen
    import tone_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 50_000_000,
    parameter longint unsigned NOTE1_MHZ = 440_000,
    parameter longint unsigned NOTE2_MHZ = 523_300,
    parameter longint unsigned NOTE3_MHZ = 659_300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] btn_i,
    output logic [3:0] dac_o,
    output logic       strobe_o
);

    localparam int unsigned PER1  = sample_period(CLK_HZ, NOTE1_MHZ);
    localparam int unsigned PER2  = sample_period(CLK_HZ, NOTE2_MHZ);
    localparam int unsigned PER3  = sample_period(CLK_HZ, NOTE3_MHZ);
    localparam int unsigned PMAX  = max3(PER1, PER2, PER3);
    localparam int unsigned CNT_W = (PMAX < 2) ? 1 : $clog2(PMAX);

    tone_sel_e sel;
    logic      tick;

    tone_key_select i_keys (
        .clk   (clk),
        .rst_n (rst_n),
        .btn_i (btn_i),
        .sel_o (sel)
    );

    tone_sample_timer #(
        .PERIOD_N1 (PER1),
        .PERIOD_N2 (PER2),
        .PERIOD_N3 (PER3),
        .CNT_W     (CNT_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .tick_o (tick)
    );

    tone_wave_stepper i_stepper (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel),
        .tick_i   (tick),
        .dac_o    (dac_o),
        .strobe_o (strobe_o)
    );

    initial begin
        assert_period_nonzero_R3: assert (PER1 >= 1 && PER2 >= 1 && PER3 >= 1);
    end

endmodule

// File: tb/test_tone_wavetable_gen.sv
// Bench: directed corner cases followed by seeded random button patterns,
// checked against a model of the required behaviour.
module test_tone_wavetable_gen;

    // CLK_HZ of 100 kHz gives note periods of 7, 6 and 5 clocks (R3).
    localparam int EXP_P [4] = '{0, 7, 6, 5};
    localparam logic [3:0] EXP_WAVE [32] = '{
        4'd8, 4'd9, 4'd11, 4'd12, 4'd13, 4'd14, 4'd14, 4'd15,
        4'd15, 4'd15, 4'd14, 4'd14, 4'd13, 4'd12, 4'd11, 4'd9,
        4'd8, 4'd7, 4'd5, 4'd4, 4'd3, 4'd2, 4'd2, 4'd1,
        4'd1, 4'd1, 4'd2, 4'd2, 4'd3, 4'd4, 4'd5, 4'd7};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] btn = 3'b000;
    logic [3:0] dac;
    logic       strobe;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    bit  mon_on   = 1'b0;

    always #5 clk = ~clk;

    tone_wavetable_gen #(.CLK_HZ(100_000)) i_tone_wavetable_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_i    (btn),
        .dac_o    (dac),
        .strobe_o (strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Lowest set bit wins (R4).
    function automatic int resolve(input logic [2:0] b);
        if (b[0]) return 1;
        if (b[1]) return 2;
        if (b[2]) return 3;
        return 0;
    endfunction

    // Monitor state.
    logic [2:0] btn_seen = 3'b000;
    int  age       = 1000;
    int  since     = 0;
    int  exp_idx   = 0;
    bit  lat_armed = 1'b0;
    bit  steady    = 1'b0;

    // Sample outputs at the falling edge and compare with the model.
    always @(negedge clk) begin
        if (mon_on && !done) begin
            int cur;
            if (btn !== btn_seen) begin
                lat_armed = (resolve(btn) != 0) && (resolve(btn) != resolve(btn_seen));
                btn_seen  = btn;
                age       = 0;
            end else begin
                age++;
            end
            since++;
            cur = resolve(btn_seen);
            if (cur == 0 && age >= 4) begin
                exp_idx = 0;
                steady  = 1'b0;
                check(dac == 4'd8 && !strobe, "R5 rest", {dac, 3'b000, strobe}, 8 << 4);
            end
            if (strobe) begin
                check(dac == EXP_WAVE[exp_idx], "R1,R2,R6 code", dac, EXP_WAVE[exp_idx]);
                if (age > 4 && cur != 0) begin
                    if (lat_armed) begin
                        check(age == EXP_P[cur] + 4, "R7 R6 first strobe", age, EXP_P[cur] + 4);
                        lat_armed = 1'b0;
                    end else if (steady) begin
                        check(since == EXP_P[cur], "R3 R4 spacing", since, EXP_P[cur]);
                    end
                    steady = 1'b1;
                end
                exp_idx = (exp_idx + 1) % 32;
                since   = 0;
            end
        end
    end

    task automatic hold(input logic [2:0] b, input int cycles);
        @(posedge clk);
        #1 btn = b;
        repeat (cycles) @(posedge clk);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        // R8: reset state while held and just after release.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dac == 4'd8 && !strobe, "R8 in reset", dac, 8);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(dac == 4'd8 && !strobe, "R8 after reset", dac, 8);
        mon_on = 1'b1;
        // Directed corners.
        hold(3'b001, 300);   // note 1, wraps the table (R2, R3)
        hold(3'b010, 100);   // switch note, position kept (R6, R7)
        hold(3'b000, 30);    // stop and rewind (R5)
        hold(3'b100, 60);    // restart from step 0 on note 3
        hold(3'b110, 60);    // priority: note 2 wins (R4)
        hold(3'b111, 60);    // priority: note 1 wins (R4)
        hold(3'b011, 40);    // same winner, no reload
        hold(3'b000, 10);
        // Seeded random patterns.
        for (int k = 0; k < 40; k++) begin
            hold(3'($urandom % 8), 20 + int'($urandom % 150));
        end
        hold(3'b000, 10);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule